// File: doc/BRIEF.md
# Ghost-Filtering Key Change Reporter

This block sits behind a key-matrix scanner. Each time the scanner has a fresh picture of the matrix, it presents up to eight key slots for one cycle with a strobe. Each slot has a valid flag, a 4-bit row number and a 3-bit column number. The block compares that picture with the set of keys it accepted last time. It then streams out release events for keys that have gone, followed by press events for every key now held. It hands these events to a consumer one at a time over a valid/ready channel.

Two filters can reject or reshape a picture before it is compared.

- **Ghost filter.** When it is enabled and three or more ordinary keys are down, the block drops the whole picture if any two keys share a row and any two keys share a column. The held set is then left untouched.
- **Modifier key.** A modifier can be named by its scancode. When it is enabled and that key is present, the key itself is never reported. Every other scancode in the picture is then moved up by the full key count of 128, which sets bit 7.

Back-pressure rules for the event channel:

- An event stays on `ev_code`/`ev_press` with `ev_valid` high until a cycle in which `ev_ready` is high; it is consumed on that edge.
- At most one event is consumed per cycle.
- While any event is pending, `busy` is high and a snapshot strobe is dropped without effect.
- The producer must re-present a dropped picture later.

Top module: `key_change_reporter`

## Requirements
- R1: An event code is {modifier-offset bit, row[3:0], col[2:0]}, i.e. row*8+col with bit 7 as the offset. Press events of one snapshot leave in ascending slot order.
- R2: A strobe is taken only in a cycle where `busy` is low. The first event appears on the following cycle. A strobe while `busy` is high changes neither the pending events nor the held set.
- R3: While `ev_valid` is high and `ev_ready` is low, `ev_valid`, `ev_code` and `ev_press` (1 = press, 0 = release) hold their values.
- R4: Every held key whose code is absent from the accepted snapshot gets a release event. The releases come in ascending order of the slot the key was held in, and all of them precede any press event.
- R5: Every key of an accepted snapshot gets a press event, including keys that were already held.
- R6: An accepted snapshot with no valid slot releases all held keys and empties the held set. A further empty snapshot produces no event.
- R7: A ghosted snapshot produces no event and leaves the held set unchanged. A snapshot is ghosted when it has at least one pair of keys on a common row and at least one pair (possibly different) on a common column.
- R8: The ghost test applies only with `ghost_en` high and at least three non-modifier keys valid. A snapshot with only shared rows, or with `ghost_en` low, is accepted.
- R9: With `fn_en` high, slots whose scancode equals `fn_code` are not reported and do not count toward R8. All other codes of that snapshot get bit 7 set. With `fn_en` low, such a slot is an ordinary key.
- R10: Reset clears pending events and the held set; `busy` and `ev_valid` are low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snap_valid | input | 1 | One-cycle strobe: snapshot present |
| snap_vld | input | 8 | Per-slot valid flags |
| snap_row | input | 32 | Per-slot row, slot s at [4s+3:4s] |
| snap_col | input | 24 | Per-slot column, slot s at [3s+2:3s] |
| fn_en | input | 1 | Enable modifier handling |
| fn_code | input | 7 | Scancode of the modifier key |
| ghost_en | input | 1 | Enable ghost rejection |
| busy | output | 1 | Events pending; strobes are dropped |
| ev_valid | output | 1 | Event available |
| ev_ready | input | 1 | Consumer accepts the event |
| ev_code | output | 8 | Event scancode |
| ev_press | output | 1 | 1 = press, 0 = release |

## Verification
The bound checker watches every cycle for four things:

- an event is frozen under back-pressure;
- no release ever follows a press within a burst;
- a burst can only begin right after a strobe;
- a burst never exceeds two events per slot.

Reset also leaves the channel quiet. Which codes are released or pressed, the ghost verdict, the modifier offset, and the fact that the held set survives rejected or dropped snapshots depend on the history of pictures. Only the bench's snapshot sequences can show those.

// File: rtl/kcr_pkg.sv
package kcr_pkg;
  typedef enum logic {EV_RELEASE = 1'b0, EV_PRESS = 1'b1} ev_kind_e;

  // index of the least significant set bit (0 when none)
  function automatic int lowest_set(input logic [63:0] m);
    int idx;
    idx = 0;
    for (int i = 63; i >= 0; i--) begin
      if (m[i]) idx = i;
    end
    return idx;
  endfunction
endpackage

// File: rtl/kcr_snap_decode.sv
module kcr_snap_decode #(
  parameter int N  = 8,
  parameter int RW = 4,
  parameter int CW = 3,
  localparam int SW = RW + CW,
  localparam int CODEW = SW + 1
) (
  input  logic [N-1:0]            vld,
  input  logic [N-1:0][RW-1:0]    row,
  input  logic [N-1:0][CW-1:0]    col,
  input  logic                    fn_en,
  input  logic [SW-1:0]           fn_code,
  input  logic                    ghost_en,
  output logic [N-1:0]            keep,
  output logic [N-1:0][CODEW-1:0] code,
  output logic                    ghosted
);
  logic [N-1:0] is_fn;
  logic         fn_seen;
  logic         share_row;
  logic         share_col;

  assign fn_seen = |is_fn;

  for (genvar s = 0; s < N; s++) begin : g_slot
    assign is_fn[s] = fn_en & vld[s] & ({row[s], col[s]} == fn_code);
    assign keep[s]  = vld[s] & ~is_fn[s];
    // offset by the full key count = set the bit above the raw scancode
    assign code[s]  = {fn_seen, row[s], col[s]};
  end

  always_comb begin
    share_row = 1'b0;
    share_col = 1'b0;
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        if (keep[i] && keep[j]) begin
          if (row[i] == row[j]) share_row = 1'b1;
          if (col[i] == col[j]) share_col = 1'b1;
        end
      end
    end
  end

  assign ghosted = ghost_en && ($countones(keep) >= 3) && share_row && share_col;
endmodule

// File: rtl/kcr_release_diff.sv
module kcr_release_diff #(
  parameter int N     = 8,
  parameter int CODEW = 8
) (
  input  logic [N-1:0]            old_msk,
  input  logic [N-1:0][CODEW-1:0] old_code,
  input  logic [N-1:0]            new_msk,
  input  logic [N-1:0][CODEW-1:0] new_code,
  output logic [N-1:0]            gone
);
  for (genvar i = 0; i < N; i++) begin : g_old
    logic [N-1:0] hit;
    for (genvar j = 0; j < N; j++) begin : g_new
      assign hit[j] = new_msk[j] && (new_code[j] == old_code[i]);
    end
    assign gone[i] = old_msk[i] & ~(|hit);
  end
endmodule

// File: rtl/kcr_event_seq.sv
module kcr_event_seq
  import kcr_pkg::*;
#(
  parameter int N     = 8,
  parameter int CODEW = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [N-1:0]            new_msk,
  input  logic [N-1:0][CODEW-1:0] new_code,
  input  logic [N-1:0]            gone,
  input  logic                    ev_ready,
  output logic                    ev_valid,
  output logic [CODEW-1:0]        ev_code,
  output logic                    ev_press,
  output logic [N-1:0]            held_msk,
  output logic [N-1:0][CODEW-1:0] held_code
);
  logic [N-1:0]            rel_msk;
  logic [N-1:0]            prs_msk;
  logic [N-1:0][CODEW-1:0] rel_code;
  logic [IW-1:0]           rsel;
  logic [IW-1:0]           psel;
  ev_kind_e                kind;

  assign rsel     = IW'(lowest_set(64'(rel_msk)));
  assign psel     = IW'(lowest_set(64'(prs_msk)));
  assign kind     = (|rel_msk) ? EV_RELEASE : EV_PRESS;
  assign ev_valid = (|rel_msk) | (|prs_msk);
  assign ev_press = (kind == EV_PRESS);
  assign ev_code  = (kind == EV_RELEASE) ? rel_code[rsel] : held_code[psel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_msk   <= '0;
      prs_msk   <= '0;
      rel_code  <= '0;
      held_msk  <= '0;
      held_code <= '0;
    end else if (load) begin
      rel_msk   <= gone;
      rel_code  <= held_code;
      held_msk  <= new_msk;
      held_code <= new_code;
      prs_msk   <= new_msk;
    end else if (ev_valid && ev_ready) begin
      if (kind == EV_RELEASE) rel_msk[rsel] <= 1'b0;
      else                    prs_msk[psel] <= 1'b0;
    end
  end
endmodule

// File: rtl/key_change_reporter.sv
module key_change_reporter #(
  parameter int N  = 8,
  parameter int RW = 4,
  parameter int CW = 3,
  localparam int SW = RW + CW,
  localparam int CODEW = SW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snap_valid,
  input  logic [N-1:0]      snap_vld,
  input  logic [N*RW-1:0]   snap_row,
  input  logic [N*CW-1:0]   snap_col,
  input  logic              fn_en,
  input  logic [SW-1:0]     fn_code,
  input  logic              ghost_en,
  output logic              busy,
  output logic              ev_valid,
  input  logic              ev_ready,
  output logic [CODEW-1:0]  ev_code,
  output logic              ev_press
);
  logic [N-1:0][RW-1:0]    row_a;
  logic [N-1:0][CW-1:0]    col_a;
  logic [N-1:0]            keep;
  logic [N-1:0][CODEW-1:0] code;
  logic                    ghosted;
  logic [N-1:0]            held_msk;
  logic [N-1:0][CODEW-1:0] held_code;
  logic [N-1:0]            gone;
  logic                    load;

  assign row_a = snap_row;
  assign col_a = snap_col;
  assign busy  = ev_valid;
  assign load  = snap_valid & ~busy & ~ghosted;

  kcr_snap_decode #(.N(N), .RW(RW), .CW(CW)) u_dec (
    .vld(snap_vld), .row(row_a), .col(col_a),
    .fn_en(fn_en), .fn_code(fn_code), .ghost_en(ghost_en),
    .keep(keep), .code(code), .ghosted(ghosted)
  );

  kcr_release_diff #(.N(N), .CODEW(CODEW)) u_diff (
    .old_msk(held_msk), .old_code(held_code),
    .new_msk(keep), .new_code(code), .gone(gone)
  );

  kcr_event_seq #(.N(N), .CODEW(CODEW)) u_seq (
    .clk(clk), .rst_n(rst_n), .load(load),
    .new_msk(keep), .new_code(code), .gone(gone),
    .ev_ready(ev_ready), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_press(ev_press), .held_msk(held_msk), .held_code(held_code)
  );
endmodule

// File: rtl/kcr_chk.sv
module kcr_chk #(
  parameter int N     = 8,
  parameter int CODEW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snap_valid,
  input logic             busy,
  input logic             ev_valid,
  input logic             ev_ready,
  input logic [CODEW-1:0] ev_code,
  input logic             ev_press
);
  logic [15:0] burst;

  always_ff @(posedge clk) begin
    if (!rst_n)                  burst <= '0;
    else if (!busy)              burst <= '0;
    else if (ev_valid && ev_ready) burst <= burst + 16'd1;
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && !ev_ready |=> ev_valid && $stable(ev_code) && $stable(ev_press));

  // R4
  release_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready && ev_press |=> !ev_valid || ev_press);

  // R2
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !ev_valid || $past(snap_valid));

  // R5
  burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst <= 16'(2 * N));

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !ev_valid && !busy);
endmodule

bind key_change_reporter kcr_chk #(.N(N), .CODEW(CODEW)) u_chk (
  .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .busy(busy),
  .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_code(ev_code), .ev_press(ev_press)
);

// File: tb/key_change_reporter_test.sv
module key_change_reporter_test;
  localparam int N = 8;

  typedef struct packed {
    logic            g;
    logic            f;
    logic [3:0]      vld;
    logic [3:0][6:0] c;
    logic [2:0]      n;
    logic [3:0][8:0] e;
    logic [3:0]      req;
  } vec_t;

  function automatic vec_t mk(int g, int f, int vld, int c0, int c1, int c2, int c3,
                              int n, int e0, int e1, int e2, int e3, int req);
    vec_t v;
    v.g = 1'(g); v.f = 1'(f); v.vld = 4'(vld);
    v.c[0] = 7'(c0); v.c[1] = 7'(c1); v.c[2] = 7'(c2); v.c[3] = 7'(c3);
    v.n = 3'(n);
    v.e[0] = 9'(e0); v.e[1] = 9'(e1); v.e[2] = 9'(e2); v.e[3] = 9'(e3);
    v.req = 4'(req);
    return v;
  endfunction

  // event notation: 9'h1xx press of code xx, 9'h0xx release; modifier code 0x3F
  localparam vec_t TBL [16] = '{
    mk(0,0,'b0001,'h11,0,0,0,     1,'h111,0,0,0,           1),  // R1 single press
    mk(0,0,'b0011,'h11,'h22,0,0,  2,'h111,'h122,0,0,       5),  // R5 re-press held key
    mk(0,0,'b0010,'h11,'h22,0,0,  2,'h011,'h122,0,0,       4),  // R4 release then press
    mk(0,0,'b1100,0,0,'h05,'h30,  3,'h022,'h105,'h130,0,   4),  // R4
    mk(0,0,'b0000,0,0,0,0,        2,'h005,'h030,0,0,       6),  // R6 release all
    mk(0,0,'b0000,0,0,0,0,        0,0,0,0,0,               6),  // R6 nothing held
    mk(1,0,'b0111,'h09,'h0A,'h11,0,0,0,0,0,0,              7),  // R7 ghost
    mk(0,0,'b0111,'h09,'h0A,'h11,0,3,'h109,'h10A,'h111,0,  8),  // R8 filter off
    mk(1,0,'b1111,'h09,'h0A,'h11,'h12,0,0,0,0,0,           7),  // R7 ghost
    mk(0,0,'b0001,'h09,0,0,0,     3,'h00A,'h011,'h109,0,   7),  // R7 held set kept
    mk(1,0,'b0111,'h08,'h09,'h1A,0,3,'h108,'h109,'h11A,0,  8),  // R8 rows only
    mk(1,0,'b1111,'h09,'h0A,'h1B,'h23,0,0,0,0,0,           7),  // R7 split pairs
    mk(0,1,'b0011,'h3F,'h09,0,0,  4,'h008,'h009,'h01A,'h189,9), // R9 offset
    mk(1,1,'b0111,'h3F,'h0F,'h39,0,3,'h089,'h18F,'h1B9,0,  9),  // R9 not counted
    mk(0,0,'b0011,'h3F,'h09,0,0,  4,'h08F,'h0B9,'h13F,'h109,9), // R9 disabled
    mk(0,0,'b0000,0,0,0,0,        2,'h03F,'h009,0,0,       6)   // R6
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, snap_valid, fn_en, ghost_en, ev_ready;
  logic [N-1:0]      snap_vld;
  logic [N-1:0][3:0] row_a;
  logic [N-1:0][2:0] col_a;
  logic [6:0]        fn_code;
  logic              busy, ev_valid, ev_press;
  logic [7:0]        ev_code;

  key_change_reporter uut (
    .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_vld(snap_vld),
    .snap_row(row_a), .snap_col(col_a), .fn_en(fn_en), .fn_code(fn_code),
    .ghost_en(ghost_en), .busy(busy), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_code(ev_code), .ev_press(ev_press)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  task automatic clear_snap();
    snap_vld = '0;
    row_a    = '0;
    col_a    = '0;
  endtask

  task automatic set_slot(int s, int code);
    snap_vld[s] = 1'b1;
    row_a[s]    = code[6:3];
    col_a[s]    = code[2:0];
  endtask

  // called at a negedge; returns at the negedge after the taking edge
  task automatic strobe();
    snap_valid = 1'b1;
    @(negedge clk);
    snap_valid = 1'b0;
  endtask

  task automatic collect(output int n, output logic [8:0] got [8]);
    ev_ready = 1'b1;
    n = 0;
    for (int k = 0; k < 8; k++) got[k] = '0;
    for (int k = 0; k < 24; k++) begin
      if (ev_valid) begin
        if (n < 8) got[n] = {ev_press, ev_code};
        n++;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    int          n;
    logic [8:0]  got [8];
    rst_n = 1'b0; snap_valid = 1'b0; ev_ready = 1'b0;
    fn_en = 1'b0; ghost_en = 1'b0; fn_code = 7'h3F;
    clear_snap();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 busy after reset", int'(busy), 0);
    chk("R10 ev_valid after reset", int'(ev_valid), 0);

    for (int v = 0; v < 16; v++) begin
      string tag;
      tag = $sformatf("R%0d vector %0d", TBL[v].req, v);
      clear_snap();
      for (int s = 0; s < 4; s++) begin
        if (TBL[v].vld[s]) set_slot(s, int'(TBL[v].c[s]));
        else begin
          row_a[s] = TBL[v].c[s][6:3];
          col_a[s] = TBL[v].c[s][2:0];
        end
      end
      ghost_en = TBL[v].g;
      fn_en    = TBL[v].f;
      strobe();
      collect(n, got);
      chk({tag, " count"}, n, int'(TBL[v].n));
      for (int k = 0; k < int'(TBL[v].n); k++)
        chk($sformatf("%s event %0d", tag, k), int'(got[k]), int'(TBL[v].e[k]));
      chk({tag, " busy idle (R2)"}, int'(busy), 0);
    end

    // back-pressure and strobe while busy: R3, R2
    fn_en = 1'b0; ghost_en = 1'b0; ev_ready = 1'b0;
    clear_snap();
    set_slot(4, 'h40);
    set_slot(7, 'h7F);
    strobe();
    chk("R2 first event next cycle", int'(ev_valid), 1);
    chk("R1 slot order first press", int'({ev_press, ev_code}), 'h140);
    clear_snap();
    set_slot(0, 'h01);
    strobe();
    repeat (2) @(negedge clk);
    chk("R3 held under back-pressure", int'({ev_press, ev_code}), 'h140);
    chk("R3 valid held", int'(ev_valid), 1);
    chk("R2 busy while pending", int'(busy), 1);
    collect(n, got);
    chk("R2 ignored strobe count", n, 2);
    chk("R2 burst event 0", int'(got[0]), 'h140);
    chk("R1 burst event 1", int'(got[1]), 'h17F);
    clear_snap();
    strobe();
    collect(n, got);
    chk("R2 held set untouched count", n, 2);
    chk("R2 release 0", int'(got[0]), 'h040);
    chk("R2 release 1", int'(got[1]), 'h07F);

    // reset clears the held set and pending events: R10
    clear_snap();
    set_slot(0, 'h55);
    set_slot(1, 'h56);
    strobe();
    collect(n, got);
    chk("R10 pre-reset presses", n, 2);
    ev_ready = 1'b0;
    strobe();
    chk("R10 burst pending before reset", int'(ev_valid), 1);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ev_valid cleared", int'(ev_valid), 0);
    chk("R10 busy cleared", int'(busy), 0);
    clear_snap();
    strobe();
    collect(n, got);
    chk("R10 held set empty after reset", n, 0);

    summary();
  end
endmodule